// File: doc/BRIEF.md
# Bus address page remapper

This block widens the reach of an 18-bit system bus into a 22-bit physical memory space. The 256 KB bus space is cut into 32 sections of 8 KB. The five top bits of each bus address pick one of 32 page base registers. The block then forms a memory address from that base and the 13-bit offset inside the section. The translation does not depend on whether the access fetches an instruction or reads data. It sees only the bus address.

The topmost 8 KB section is the I/O page. An address in it is never sent to memory. It leaves the block unchanged, zero-extended, and is flagged as I/O. The block's own base registers sit in this page, so they stay reachable whatever the bases hold.

Software reads and writes the bases as 16-bit words through a 32-word window in the I/O page. Each word has byte-lane enables. The result of a translation appears one clock after the request. A write to a base changes translations that are requested from the next cycle on.

Top module: `bus_page_remap`

## Requirements
- R1: After reset, base register i holds i×128, so that the low 256 KB of memory is mapped one to one.
- R2: When req_valid is high and req_addr[17:13] is not 31, one clock later xl_valid=1, xl_mem=1 and xl_addr = (base[req_addr[17:13]] × 64 + req_addr[12:0]) mod 2^22.
- R3: When req_valid is high and req_addr[17:13] = 31, one clock later xl_valid=1, xl_mem=0 and xl_addr equals req_addr zero-extended to 22 bits.
- R4: cfg_hit is high, and cfg_rdata returns base register k at once, exactly when cfg_addr = octal 763700 + 2k for k in 0..31 (even addresses only). Any other cfg_addr gives cfg_hit=0 and cfg_rdata=0.
- R5: A clock edge with cfg_wr=1, cfg_hit=1 and cfg_be=2'b11 loads cfg_wdata into the addressed base register.
- R6: Each byte enable is applied on its own. cfg_be[0] writes bits [7:0] and cfg_be[1] writes bits [15:8]. A lane whose enable is low keeps its old value.
- R7: A translation requested on the same edge as a write to its base register uses the old base. A translation requested on the next edge uses the new base.
- R8: xl_valid is high exactly one clock after req_valid was high. In a cycle after req_valid was low, xl_valid is 0 and xl_addr and xl_mem hold their values.
- R9: A write with cfg_hit=0 changes no base register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A bus address is presented for translation |
| req_addr | input | 18 | Incoming bus byte address |
| xl_valid | output | 1 | Registered result is valid |
| xl_addr | output | 22 | Translated memory address, or I/O address passed through |
| xl_mem | output | 1 | 1 = memory access, 0 = I/O page passthrough |
| cfg_addr | input | 18 | Bus byte address of a register access |
| cfg_wr | input | 1 | Write strobe for the register window |
| cfg_be | input | 2 | Byte-lane enables for a write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of the addressed base register, combinational |
| cfg_hit | output | 1 | cfg_addr falls on a word of the window |

## Verification
Translations are tried on identity bases after reset, on bases rewritten at random, and on the largest base, where the sum wraps past 22 bits. These cases separate a wrong shift or a wrong truncation from a wrong register select. Addresses in the top section show whether the I/O page bypasses translation. Writes are mixed with requests to the same section on the same edge and on the next edge, which shows the ordering of update and lookup. Partial byte enables and writes that miss the window show whether untouched lanes and registers keep their values.

// File: rtl/remap_pkg.sv
package remap_pkg;
   // lane count for a register of the given width
   function automatic int lanes_of(input int width);
      return width / 8;
   endfunction
endpackage

// File: rtl/remap_regfile.sv
module remap_regfile
   import remap_pkg::*;
#(
   parameter int BUS_AW     = 18,
   parameter int NUM_REGS   = 32,
   parameter int BASE_W     = 16,
   parameter int BASE_SHIFT = 6,
   parameter logic [BUS_AW-1:0] WIN_BASE = 18'o763700
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [BUS_AW-1:0]           cfg_addr,
   input  logic                        cfg_wr,
   input  logic [lanes_of(BASE_W)-1:0] cfg_be,
   input  logic [BASE_W-1:0]           cfg_wdata,
   output logic [BASE_W-1:0]           cfg_rdata,
   output logic                        cfg_hit,
   input  logic [$clog2(NUM_REGS)-1:0] lk_idx,
   output logic [BASE_W-1:0]           lk_base
);
   localparam int IDX_W      = $clog2(NUM_REGS);
   localparam int LANES      = lanes_of(BASE_W);
   localparam int PAGE_OFF_W = BUS_AW - IDX_W;

   generate
      if (BASE_W % 8 != 0) begin : g_bad_width
         $error("BASE_W must be a whole number of bytes");
      end
      if (LANES != 2) begin : g_bad_lanes
         $error("window words are two bytes wide");
      end
      if (WIN_BASE % (2 * NUM_REGS) != 0) begin : g_bad_align
         $error("window base must align to its size");
      end
   endgenerate

   logic [BASE_W-1:0]   bases [NUM_REGS];
   logic [IDX_W-1:0]    win_idx;
   logic [NUM_REGS-1:0] wr_sel;

   assign win_idx   = cfg_addr[IDX_W:1];
   assign cfg_hit   = (cfg_addr[BUS_AW-1:IDX_W+1] == WIN_BASE[BUS_AW-1:IDX_W+1])
                      && !cfg_addr[0];
   assign cfg_rdata = cfg_hit ? bases[win_idx] : '0;
   assign lk_base   = bases[lk_idx];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         localparam logic [BUS_AW-1:0] SECT_START = BUS_AW'(i) << PAGE_OFF_W;
         localparam logic [BASE_W-1:0] RST_VAL    = BASE_W'(SECT_START >> BASE_SHIFT);

         assign wr_sel[i] = cfg_wr && cfg_hit && (win_idx == IDX_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bases[i] <= RST_VAL;
            end else if (wr_sel[i]) begin
               for (int b = 0; b < LANES; b++) begin
                  if (cfg_be[b]) bases[i][8*b +: 8] <= cfg_wdata[8*b +: 8];
               end
            end
         end
      end
   endgenerate

   // R5: at most one register is written per edge
   p_one_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));

   // R5: a full word write lands in the addressed register
   p_word_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_hit && cfg_be == 2'b11) |=> (bases[$past(win_idx)] == $past(cfg_wdata)));

   // R6: a low-lane-only write keeps the high byte
   p_keep_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_hit && cfg_be == 2'b01)
      |=> (bases[$past(win_idx)][15:8] == $past(bases[win_idx][15:8])));
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate #(
   parameter int BUS_AW     = 18,
   parameter int PHYS_AW    = 22,
   parameter int IDX_W      = 5,
   parameter int BASE_W     = 16,
   parameter int BASE_SHIFT = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [BUS_AW-1:0]  req_addr,
   input  logic [BASE_W-1:0]  base,
   output logic               xl_valid,
   output logic [PHYS_AW-1:0] xl_addr,
   output logic               xl_mem
);
   localparam int PAGE_OFF_W = BUS_AW - IDX_W;

   generate
      if (PHYS_AW < BUS_AW) begin : g_bad_phys
         $error("physical space must be at least as wide as the bus");
      end
      if (BASE_SHIFT >= PAGE_OFF_W) begin : g_bad_shift
         $error("base granularity must be finer than a section");
      end
   endgenerate

   logic               in_io;
   logic [PHYS_AW-1:0] mem_addr;
   logic [PHYS_AW-1:0] next_addr;

   assign in_io     = &req_addr[BUS_AW-1:PAGE_OFF_W];
   assign mem_addr  = (PHYS_AW'(base) << BASE_SHIFT) + PHYS_AW'(req_addr[PAGE_OFF_W-1:0]);
   assign next_addr = in_io ? PHYS_AW'(req_addr) : mem_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xl_valid <= 1'b0;
         xl_addr  <= '0;
         xl_mem   <= 1'b0;
      end else begin
         xl_valid <= req_valid;
         if (req_valid) begin
            xl_addr <= next_addr;
            xl_mem  <= !in_io;
         end
      end
   end

   // R8: result follows a request by one clock
   p_valid_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> xl_valid);

   // R8: outputs hold while idle
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!xl_valid && $stable(xl_addr) && $stable(xl_mem)));

   // R3: I/O page passes through untranslated
   p_io_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && in_io) |=> (!xl_mem && xl_addr == PHYS_AW'($past(req_addr))));

   // R2: offset bits below the base granularity are carried unchanged
   p_low_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !in_io) |=> (xl_mem && xl_addr[BASE_SHIFT-1:0] == $past(req_addr[BASE_SHIFT-1:0])));
endmodule

// File: rtl/bus_page_remap.sv
module bus_page_remap #(
   parameter int BUS_AW     = 18,
   parameter int PHYS_AW    = 22,
   parameter int NUM_REGS   = 32,
   parameter int BASE_W     = 16,
   parameter int BASE_SHIFT = 6,
   parameter logic [BUS_AW-1:0] WIN_BASE = 18'o763700
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [BUS_AW-1:0]   req_addr,
   output logic                xl_valid,
   output logic [PHYS_AW-1:0]  xl_addr,
   output logic                xl_mem,
   input  logic [BUS_AW-1:0]   cfg_addr,
   input  logic                cfg_wr,
   input  logic [BASE_W/8-1:0] cfg_be,
   input  logic [BASE_W-1:0]   cfg_wdata,
   output logic [BASE_W-1:0]   cfg_rdata,
   output logic                cfg_hit
);
   localparam int IDX_W = $clog2(NUM_REGS);

   generate
      if ((1 << IDX_W) != NUM_REGS) begin : g_bad_count
         $error("NUM_REGS must be a power of two");
      end
      if (WIN_BASE[BUS_AW-1:BUS_AW-IDX_W] != {IDX_W{1'b1}}) begin : g_bad_win
         $error("register window must sit in the I/O page");
      end
   endgenerate

   logic [IDX_W-1:0]  lk_idx;
   logic [BASE_W-1:0] lk_base;

   assign lk_idx = req_addr[BUS_AW-1:BUS_AW-IDX_W];

   remap_regfile #(
      .BUS_AW(BUS_AW), .NUM_REGS(NUM_REGS), .BASE_W(BASE_W),
      .BASE_SHIFT(BASE_SHIFT), .WIN_BASE(WIN_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_hit(cfg_hit),
      .lk_idx(lk_idx), .lk_base(lk_base)
   );

   remap_xlate #(
      .BUS_AW(BUS_AW), .PHYS_AW(PHYS_AW), .IDX_W(IDX_W),
      .BASE_W(BASE_W), .BASE_SHIFT(BASE_SHIFT)
   ) u_xlate (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .base(lk_base),
      .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_mem(xl_mem)
   );
endmodule

// File: tb/tb_bus_page_remap.sv
module tb_bus_page_remap;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [17:0] req_addr = '0;
   logic        xl_valid;
   logic [21:0] xl_addr;
   logic        xl_mem;
   logic [17:0] cfg_addr = '0;
   logic        cfg_wr = 1'b0;
   logic [1:0]  cfg_be = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        cfg_hit;

   int total = 0;
   int bad = 0;
   logic [15:0] model [32];

   always #10 clk = ~clk;

   bus_page_remap dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .xl_valid(xl_valid), .xl_addr(xl_addr), .xl_mem(xl_mem),
      .cfg_addr(cfg_addr), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_hit(cfg_hit)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic bit win_hit(input logic [17:0] a);
      return (a[17:6] == 12'o7637) && !a[0];
   endfunction

   function automatic logic [15:0] win_read(input logic [17:0] a);
      return win_hit(a) ? model[a[5:1]] : 16'h0;
   endfunction

   function automatic logic [21:0] exp_xl(input logic [17:0] a);
      if (a[17:13] == 5'd31) return {4'b0, a};
      return ({6'b0, model[a[17:13]]} << 6) + {9'b0, a[12:0]};
   endfunction

   // one clock: drive at negedge, check read at once, check result at next negedge
   task automatic step(input bit rv, input logic [17:0] ra, input bit wr,
                       input logic [17:0] ca, input logic [1:0] be, input logic [15:0] wd,
                       input string tag);
      logic [21:0] ea;
      logic [21:0] held_a;
      logic        held_m;
      req_valid = rv; req_addr = ra; cfg_wr = wr; cfg_addr = ca; cfg_be = be; cfg_wdata = wd;
      held_a = xl_addr; held_m = xl_mem;
      #1;
      chk(cfg_hit == win_hit(ca), "R4 hit", 32'(cfg_hit), 32'(win_hit(ca)));
      chk(cfg_rdata == win_read(ca), "R4 read", 32'(cfg_rdata), 32'(win_read(ca)));
      ea = exp_xl(ra);
      @(posedge clk);
      @(negedge clk);
      if (rv) begin
         chk(xl_valid == 1'b1, "R8 valid", 32'(xl_valid), 1);
         chk(xl_mem == (ra[17:13] != 5'd31), {tag, " mem flag"}, 32'(xl_mem), 32'(ra[17:13] != 5'd31));
         chk(xl_addr == ea, tag, 32'(xl_addr), 32'(ea));
      end else begin
         chk(!xl_valid && xl_addr == held_a && xl_mem == held_m, "R8 hold",
             {9'b0, xl_valid, xl_addr}, {10'b0, held_a});
      end
      if (wr && win_hit(ca)) begin
         if (be[0]) model[ca[5:1]][7:0]  = wd[7:0];
         if (be[1]) model[ca[5:1]][15:8] = wd[15:8];
      end
      req_valid = 1'b0; cfg_wr = 1'b0;
   endtask

   function automatic logic [17:0] reg_addr(input int k);
      return 18'o763700 + 18'(2 * k);
   endfunction

   initial begin
      #(200000 * 20);
      bad++; total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed;
      seed = 7;
      void'($urandom(seed));
      for (int i = 0; i < 32; i++) model[i] = 16'(i * 128);
      repeat (3) @(negedge clk);
      chk(xl_valid == 1'b0 && xl_addr == 22'h0, "R8 reset", {9'b0, xl_valid, xl_addr}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: identity bases after reset
      for (int k = 0; k < 32; k++) begin
         cfg_addr = reg_addr(k);
         #1;
         chk(cfg_rdata == 16'(k * 128), "R1 reset base", 32'(cfg_rdata), 32'(k * 128));
      end
      // R2 identity translation, R3 I/O page
      step(1, 18'o123456, 0, 0, 0, 0, "R2 identity");
      step(1, 18'o763702, 0, 0, 0, 0, "R3 io page");
      step(1, 18'o777777, 0, 0, 0, 0, "R3 io top");
      step(0, 18'o000100, 0, 0, 0, 0, "R8 idle");
      // R7 same-edge write uses old base, next edge uses new (R5 word write)
      step(1, 18'o060123, 1, reg_addr(3), 2'b11, 16'h1234, "R7 old base");
      step(1, 18'o060123, 0, reg_addr(3), 0, 0, "R7 new base R5");
      // R6 byte lanes
      step(0, 0, 1, reg_addr(5), 2'b01, 16'hABCD, "R6");
      step(0, 0, 1, reg_addr(6), 2'b10, 16'hABCD, "R6");
      step(1, 18'o120007, 0, reg_addr(5), 0, 0, "R6 low lane");
      step(1, 18'o140007, 0, reg_addr(6), 0, 0, "R6 high lane");
      // R9 writes that miss the window
      step(0, 0, 1, 18'o763600, 2'b11, 16'hFFFF, "R9");
      step(0, 0, 1, reg_addr(7) | 18'd1, 2'b11, 16'hFFFF, "R9");
      step(0, 0, 1, 18'o001700, 2'b11, 16'hFFFF, "R9");
      for (int k = 0; k < 32; k++) begin
         cfg_addr = reg_addr(k);
         #1;
         chk(cfg_rdata == model[k], "R9 untouched", 32'(cfg_rdata), 32'(model[k]));
      end
      // R2 wrap past 22 bits
      step(0, 0, 1, reg_addr(0), 2'b11, 16'hFFFF, "R5");
      step(1, 18'o017777, 0, reg_addr(0), 0, 0, "R2 wrap");
      // random mix
      for (int n = 0; n < 600; n++) begin
         logic [17:0] ra;
         logic [17:0] ca;
         bit          wr;
         ra = 18'($urandom);
         wr = ($urandom % 3) == 0;
         case ($urandom % 4)
            0: ca = 18'($urandom);
            1: ca = reg_addr(ra[17:13]);
            default: ca = reg_addr(int'($urandom % 32));
         endcase
         step(($urandom % 5) != 0, ra, wr, ca, 2'($urandom), 16'($urandom),
              (ra[17:13] == 5'd31) ? "R3 random" : "R2 random");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule